// File: doc/BRIEF.md
# Load-Multiple Descending Sequencer

This block takes one load-multiple instruction of the kind whose memory words lie just below the base address. It decodes the instruction in either of two forms, a 32-bit conditional word or a 32-bit compact form made of two halfwords. It then loads the selected registers one at a time. For each selected register it sends one word read over a valid/ready request channel. When the matching response arrives, it writes the returned word to the register file through a single write port.

The caller passes in the base register's current value together with the instruction. The caller also supplies two facts about the conditional-execution block: whether the instruction sits inside one, and whether it is the last instruction there. Several things stay outside the block: condition testing, memory, register storage, alignment faults and mode switching. The block does three further things beyond the loads. A selected program counter turns into a branch request. An optional base update is sent through the same write port. Any encoding whose outcome is unpredictable raises a level flag.

Back-pressure works as follows. An instruction is taken only while `instr_ready` is high, which happens only when the block is idle. A memory request stays valid with a stable address until `mem_req_ready` is seen high. Only one read is ever outstanding. `mem_rsp_ready` is high only while a response is awaited, and a response offered at any other time is not consumed.

Top module: `lmdb_sequencer`

## Requirements
- R1: With n selected registers, the first read address is base − 4·n, and each later read address is 4 above the previous one.
- R2: Registers are loaded in ascending index order. Register k (k ≠ 15) receives the response word in a write with `rf_waddr` = k and `rf_wdata` equal to that word.
- R3: When writeback is set, one extra write to Rn with the value base − 4·n follows the last register load. When writeback is clear, Rn is written only if it is in the list, and then it keeps the loaded word.
- R4: Register 15 in the list never produces a register write. Its loaded word appears on `branch_target`, and `branch_valid` is high in the same cycle as `done`.
- R5: Conditional form (`instr_compact` = 0) is recognised by bits 27:23 = 10010, bit 22 = 0 and bit 20 = 1. In this form, bit 21 is writeback, bits 19:16 are Rn and bits 15:0 are the list. Bits 31:28 are ignored.
- R6: Compact form (`instr_compact` = 1) has its first halfword in bits 31:16 and its second halfword in bits 15:0.
  - The first halfword must read 1110100100 in bits 15:6 and 1 in bit 4. Its bit 5 is writeback and its bits 3:0 are Rn.
  - The second halfword supplies bit 15 → register 15 and bit 14 → register 14. Register 13 is never selected. Bits 12:0 select registers 12..0.
- R7: In the compact form, `unpredictable` is raised when any of these holds:
  - Rn = 15;
  - fewer than two registers are selected;
  - bits 15 and 14 of the second halfword are both set;
  - writeback is set with Rn in the list;
  - register 15 is selected while inside a conditional block but not in its last slot.
- R8: In the conditional form, `unpredictable` is raised when Rn = 15, when the list is empty, or (for architecture version 7 or later) when writeback is set with Rn in the list.
- R9: A request holds its valid and address until accepted. No new request is issued until the previous response has been consumed and written.
- R10: `done` is a single-cycle pulse in the cycle after the last write. `instr_ready` is low from the cycle after acceptance until `done`.
- R11: A word that matches neither form raises `unpredictable` and finishes with `done` without any read or write.
- R12: An empty conditional-form list issues no read. If writeback is set, it writes the unchanged base to Rn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Block idle, instruction taken on valid & ready |
| instr_word | input | 32 | Instruction bits |
| instr_compact | input | 1 | 1 = two-halfword compact form |
| instr_base | input | ADDR_W | Current value of the base register |
| in_it_block | input | 1 | Instruction lies inside a conditional block |
| it_last_slot | input | 1 | Instruction is the last one of that block |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Read word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block awaits read data |
| mem_rsp_data | input | DATA_W | Read data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 4 | Register index written |
| rf_wdata | output | DATA_W | Register write data |
| branch_valid | output | 1 | Branch to loaded value requested |
| branch_target | output | DATA_W | Branch destination |
| done | output | 1 | Instruction finished (one cycle) |
| unpredictable | output | 1 | Flag for the last accepted instruction, held until the next |

## Verification
The hardest situation to reach from the ports is a request held under back-pressure while a response is still pending. The bench drives this by toggling `mem_req_ready` every cycle. It also counts any request that is still raised after a handshake whose response has not yet been delivered. The legality rules that depend on the conditional-block inputs need a register-15 list entered twice, once with the last-slot input low and once high. The bench sends both cases and compares the flag. An empty list with writeback set is sent to reach the path that goes straight to the base update with no memory traffic.

// File: rtl/lmdb_pkg.sv
`timescale 1ns/1ps
package lmdb_pkg;
  localparam int LIST_W = 16;
  localparam int CNT_W  = $clog2(LIST_W + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WAIT, S_WB, S_DONE
  } seq_state_e;

  typedef struct packed {
    logic [LIST_W-1:0] regs;
    logic [3:0]        rn;
    logic              wback;
    logic              unpred;
  } ldm_dec_t;

  function automatic logic [CNT_W-1:0] count_ones(input logic [LIST_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < LIST_W; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/lmdb_decode.sv
`timescale 1ns/1ps
module lmdb_decode
  import lmdb_pkg::*;
#(
  parameter int ARCH_VERSION = 7
) (
  input  logic [31:0] instr,
  input  logic        compact,
  input  logic        in_it,
  input  logic        it_last,
  output ldm_dec_t    dec
);
  always_comb begin
    logic [15:0]       hw_a;
    logic [15:0]       hw_b;
    logic [LIST_W-1:0] lst;
    logic [CNT_W-1:0]  cnt;
    logic              match;
    hw_a = instr[31:16];
    hw_b = instr[15:0];
    dec  = '0;
    if (compact) begin
      match     = (hw_a[15:6] == 10'b1110100100) && hw_a[4];
      dec.wback = hw_a[5];
      dec.rn    = hw_a[3:0];
      lst       = {hw_b[15], hw_b[14], 1'b0, hw_b[12:0]};
      cnt       = count_ones(lst);
      dec.unpred = (dec.rn == 4'hF) || (cnt < CNT_W'(2)) || (hw_b[15] && hw_b[14]) ||
                   (dec.wback && lst[dec.rn]) || (lst[15] && in_it && !it_last);
    end else begin
      match     = (instr[27:23] == 5'b10010) && !instr[22] && instr[20];
      dec.wback = instr[21];
      dec.rn    = instr[19:16];
      lst       = instr[15:0];
      cnt       = count_ones(lst);
      dec.unpred = (dec.rn == 4'hF) || (cnt == '0) ||
                   ((ARCH_VERSION >= 7) && dec.wback && lst[dec.rn]);
    end
    dec.regs = lst;
    if (!match) begin
      dec.regs   = '0;
      dec.wback  = 1'b0;
      dec.unpred = 1'b1;
    end
  end
endmodule

// File: rtl/lmdb_lowbit.sv
`timescale 1ns/1ps
module lmdb_lowbit #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/lmdb_seq.sv
`timescale 1ns/1ps
module lmdb_seq
  import lmdb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  ldm_dec_t          dec,
  input  logic [ADDR_W-1:0] base,
  output logic              idle,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rf_we,
  output logic [3:0]        rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              branch_valid,
  output logic [DATA_W-1:0] branch_target,
  output logic              done,
  output logic              unpred
);
  seq_state_e        state;
  logic [LIST_W-1:0] pend;
  logic [3:0]        rn_q;
  logic              wb_q;
  logic [ADDR_W-1:0] low_q;
  logic [ADDR_W-1:0] addr_q;
  logic              pc_hit;
  logic [DATA_W-1:0] pc_val;
  logic [3:0]        cur;
  logic [ADDR_W-1:0] low_next;

  lmdb_lowbit #(.N(LIST_W)) u_pick (.vec(pend), .idx(cur));

  assign low_next = base - (ADDR_W'(count_ones(dec.regs)) << 2);

  wire take = (state == S_WAIT) && mem_rsp_valid;
  wire last = ((pend & ~(LIST_W'(1) << cur)) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pend   <= '0;
      rn_q   <= '0;
      wb_q   <= 1'b0;
      low_q  <= '0;
      addr_q <= '0;
      pc_hit <= 1'b0;
      pc_val <= '0;
      unpred <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          pend   <= dec.regs;
          rn_q   <= dec.rn;
          wb_q   <= dec.wback;
          low_q  <= low_next;
          addr_q <= low_next;
          pc_hit <= 1'b0;
          unpred <= dec.unpred;
          if (dec.regs != '0) state <= S_REQ;
          else                state <= dec.wback ? S_WB : S_DONE;
        end
        S_REQ: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (take) begin
          pend[cur] <= 1'b0;
          addr_q    <= addr_q + ADDR_W'(4);
          if (cur == 4'hF) begin
            pc_hit <= 1'b1;
            pc_val <= mem_rsp_data;
          end
          if (last) state <= wb_q ? S_WB : S_DONE;
          else      state <= S_REQ;
        end
        S_WB:    state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    idle          = (state == S_IDLE);
    mem_req_valid = (state == S_REQ);
    mem_req_addr  = addr_q;
    mem_rsp_ready = (state == S_WAIT);
    rf_we         = (take && cur != 4'hF) || (state == S_WB);
    rf_waddr      = (state == S_WB) ? rn_q : cur;
    rf_wdata      = (state == S_WB) ? DATA_W'(low_q) : mem_rsp_data;
    done          = (state == S_DONE);
    branch_valid  = (state == S_DONE) && pc_hit;
    branch_target = pc_val;
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_REQ && $past(state) == S_WAIT) |-> mem_req_addr == $past(mem_req_addr) + ADDR_W'(4));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && idle);
  assert_no_pc_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && mem_rsp_ready |-> rf_waddr != 4'hF);
endmodule

// File: rtl/lmdb_sequencer.sv
`timescale 1ns/1ps
module lmdb_sequencer
  import lmdb_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int ARCH_VERSION = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [31:0]       instr_word,
  input  logic              instr_compact,
  input  logic [ADDR_W-1:0] instr_base,
  input  logic              in_it_block,
  input  logic              it_last_slot,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rf_we,
  output logic [3:0]        rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              branch_valid,
  output logic [DATA_W-1:0] branch_target,
  output logic              done,
  output logic              unpredictable
);
  ldm_dec_t dec;
  logic     idle;

  lmdb_decode #(.ARCH_VERSION(ARCH_VERSION)) u_dec (
    .instr(instr_word), .compact(instr_compact),
    .in_it(in_it_block), .it_last(it_last_slot), .dec(dec)
  );

  lmdb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(instr_valid && idle), .dec(dec),
    .base(instr_base), .idle(idle),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .branch_valid(branch_valid), .branch_target(branch_target),
    .done(done), .unpred(unpredictable)
  );

  assign instr_ready = idle;

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_ready |=> !instr_ready);
endmodule

// File: tb/lmdb_sequencer_test.sv
`timescale 1ns/1ps
module lmdb_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_word = '0;
  logic        instr_compact = 1'b0;
  logic [31:0] instr_base = '0;
  logic        in_it_block = 1'b0;
  logic        it_last_slot = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        branch_valid;
  logic [31:0] branch_target;
  logic        done;
  logic        unpredictable;

  always #2 clk = ~clk;

  lmdb_sequencer uut (.*);

  int n_chk = 0, n_bad = 0;
  int nreq = 0, nwr = 0, ndone = 0, nbr = 0, viol = 0;
  logic [31:0] req_a [0:31];
  logic [3:0]  wr_i  [0:31];
  logic [31:0] wr_d  [0:31];
  logic [31:0] br_t;
  logic stall = 1'b0, ph = 1'b0, pend = 1'b0;
  logic [31:0] pend_a;

  function automatic logic [31:0] md(input logic [31:0] a);
    return a * 32'd3 + 32'h0101_0000;
  endfunction
  function automatic logic [31:0] cw(input logic w, input logic [3:0] rn, input logic [15:0] l);
    return {4'hE, 5'b10010, 1'b0, w, 1'b1, rn, l};
  endfunction
  function automatic logic [31:0] tw(input logic w, input logic [3:0] rn, input logic p,
                                     input logic m, input logic [12:0] l);
    return {10'b1110100100, w, 1'b1, rn, p, m, 1'b0, l};
  endfunction

  // memory model
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend && mem_req_valid) viol++;
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = md(pend_a);
        pend = 1'b0;
      end
      ph = ~ph;
      mem_req_ready = !stall || ph;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1'b1;
        pend_a = mem_req_addr;
        if (nreq < 32) req_a[nreq] = mem_req_addr;
        nreq++;
      end
    end
  end

  // output monitor
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (rf_we) begin
        if (nwr < 32) begin wr_i[nwr] = rf_waddr; wr_d[nwr] = rf_wdata; end
        nwr++;
      end
      if (done) ndone++;
      if (branch_valid) begin nbr++; br_t = branch_target; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic cmp, input logic [31:0] base,
                     input logic it, input logic itl, output logic busy_rdy);
    nreq = 0; nwr = 0; ndone = 0; nbr = 0; viol = 0;
    @(negedge clk);
    instr_word = w; instr_compact = cmp; instr_base = base;
    in_it_block = it; it_last_slot = itl; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    #1 busy_rdy = instr_ready;
    for (int k = 0; k < 300 && ndone == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ndone == 1, "R10 one done", ndone, 1);
  endtask

  task automatic chk_wr(input int i, input logic [3:0] r, input logic [31:0] d, input string tag);
    chk(wr_i[i] == r, tag, {28'd0, wr_i[i]}, {28'd0, r});
    chk(wr_d[i] == d, tag, wr_d[i], d);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(instr_ready == 1'b1, "R10 reset ready", {31'd0, instr_ready}, 1);
    chk(!mem_req_valid && !rf_we && !done, "R10 reset quiet", {29'd0, mem_req_valid, rf_we, done}, 0);
  endtask

  task automatic t_plain();
    logic b;
    run(cw(1'b0, 4'd2, 16'h0092), 1'b0, 32'h1000, 1'b0, 1'b0, b);
    chk(b == 1'b0, "R10 busy not ready", {31'd0, b}, 0);
    chk(nreq == 3, "R1 req count", nreq, 3);
    chk(req_a[0] == 32'h0FF4, "R1 first addr", req_a[0], 32'h0FF4);
    chk(req_a[2] == 32'h0FFC, "R1 last addr", req_a[2], 32'h0FFC);
    chk(nwr == 3, "R3 no base write", nwr, 3);
    chk_wr(0, 4'd1, md(32'h0FF4), "R2 r1");
    chk_wr(1, 4'd4, md(32'h0FF8), "R2 r4");
    chk_wr(2, 4'd7, md(32'h0FFC), "R2 r7");
    chk(unpredictable == 1'b0, "R5 legal cond", {31'd0, unpredictable}, 0);
  endtask

  task automatic t_stall_wb();
    logic b;
    stall = 1'b1;
    run(cw(1'b1, 4'd5, 16'h0009), 1'b0, 32'h2000, 1'b0, 1'b0, b);
    stall = 1'b0;
    chk(viol == 0, "R9 single outstanding", viol, 0);
    chk(nreq == 2 && req_a[1] == 32'h1FFC, "R9 stalled addrs", req_a[1], 32'h1FFC);
    chk(nwr == 3, "R3 write count", nwr, 3);
    chk_wr(0, 4'd0, md(32'h1FF8), "R2 r0");
    chk_wr(1, 4'd3, md(32'h1FFC), "R2 r3");
    chk_wr(2, 4'd5, 32'h1FF8, "R3 base update");
  endtask

  task automatic t_pc();
    logic b;
    run(cw(1'b0, 4'd1, 16'h8004), 1'b0, 32'h0400, 1'b0, 1'b0, b);
    chk(nwr == 1, "R4 no pc write", nwr, 1);
    chk_wr(0, 4'd2, md(32'h03F8), "R4 r2");
    chk(nbr == 1, "R4 branch pulse", nbr, 1);
    chk(br_t == md(32'h03FC), "R4 target", br_t, md(32'h03FC));
  endtask

  task automatic t_compact();
    logic b;
    run(tw(1'b1, 4'd3, 1'b1, 1'b0, 13'h0003), 1'b1, 32'h3000, 1'b0, 1'b0, b);
    chk(nreq == 3 && req_a[0] == 32'h2FF4, "R6 first addr", req_a[0], 32'h2FF4);
    chk(nwr == 3, "R6 writes", nwr, 3);
    chk_wr(0, 4'd0, md(32'h2FF4), "R6 r0");
    chk_wr(1, 4'd1, md(32'h2FF8), "R6 r1");
    chk_wr(2, 4'd3, 32'h2FF4, "R6 base");
    chk(nbr == 1 && br_t == md(32'h2FFC), "R6 pc", br_t, md(32'h2FFC));
    chk(unpredictable == 1'b0, "R6 legal", {31'd0, unpredictable}, 0);
    run(tw(1'b0, 4'd2, 1'b0, 1'b1, 13'h0001), 1'b1, 32'h0100, 1'b0, 1'b0, b);
    chk(nwr == 2, "R6 m count", nwr, 2);
    chk_wr(1, 4'd14, md(32'h00FC), "R6 r14");
  endtask

  task automatic t_compact_flags();
    logic b;
    run(tw(1'b0, 4'd2, 1'b1, 1'b1, 13'h0003), 1'b1, 32'h800, 1'b0, 1'b0, b);
    chk(unpredictable, "R7 p and m", {31'd0, unpredictable}, 1);
    run(tw(1'b0, 4'd1, 1'b0, 1'b0, 13'h0004), 1'b1, 32'h800, 1'b0, 1'b0, b);
    chk(unpredictable, "R7 single reg", {31'd0, unpredictable}, 1);
    run(tw(1'b0, 4'd15, 1'b0, 1'b0, 13'h0006), 1'b1, 32'h800, 1'b0, 1'b0, b);
    chk(unpredictable, "R7 rn15", {31'd0, unpredictable}, 1);
    run(tw(1'b1, 4'd2, 1'b0, 1'b0, 13'h0006), 1'b1, 32'h800, 1'b0, 1'b0, b);
    chk(unpredictable, "R7 wb rn in list", {31'd0, unpredictable}, 1);
    run(tw(1'b0, 4'd4, 1'b1, 1'b0, 13'h0003), 1'b1, 32'h800, 1'b1, 1'b0, b);
    chk(unpredictable, "R7 pc mid block", {31'd0, unpredictable}, 1);
    run(tw(1'b0, 4'd4, 1'b1, 1'b0, 13'h0003), 1'b1, 32'h800, 1'b1, 1'b1, b);
    chk(!unpredictable, "R7 pc last slot", {31'd0, unpredictable}, 0);
    run(tw(1'b0, 4'd2, 1'b0, 1'b0, 13'h0006), 1'b1, 32'h800, 1'b0, 1'b0, b);
    chk(!unpredictable, "R7 rn in list no wb", {31'd0, unpredictable}, 0);
    chk(nwr == 2, "R3 loaded wins count", nwr, 2);
    chk_wr(1, 4'd2, md(32'h07FC), "R3 loaded wins");
  endtask

  task automatic t_cond_flags();
    logic b;
    run(cw(1'b0, 4'd15, 16'h0003), 1'b0, 32'h900, 1'b0, 1'b0, b);
    chk(unpredictable, "R8 rn15", {31'd0, unpredictable}, 1);
    run(cw(1'b1, 4'd1, 16'h0003), 1'b0, 32'h900, 1'b0, 1'b0, b);
    chk(unpredictable, "R8 wb rn in list", {31'd0, unpredictable}, 1);
    run(cw(1'b0, 4'd1, 16'h0003), 1'b0, 32'h900, 1'b0, 1'b0, b);
    chk(!unpredictable, "R8 legal", {31'd0, unpredictable}, 0);
    run(cw(1'b1, 4'd4, 16'h0000), 1'b0, 32'h0500, 1'b0, 1'b0, b);
    chk(unpredictable, "R8 empty", {31'd0, unpredictable}, 1);
    chk(nreq == 0, "R12 no reads", nreq, 0);
    chk(nwr == 1, "R12 one write", nwr, 1);
    chk_wr(0, 4'd4, 32'h0500, "R12 base kept");
  endtask

  task automatic t_bad();
    logic b;
    run({4'hE, 5'b10010, 3'b000, 4'd2, 16'h00FF}, 1'b0, 32'hA00, 1'b0, 1'b0, b);
    chk(unpredictable, "R11 flag", {31'd0, unpredictable}, 1);
    chk(nreq == 0 && nwr == 0, "R11 no traffic", nreq + nwr, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_stall_wb();
    t_pc();
    t_compact();
    t_compact_flags();
    t_cond_flags();
    t_bad();
    summary();
  end
endmodule